// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block maintains the linked list of extended capability headers that sits in the upper part of a 4 KB configuration space. The list lives in a single-port dword memory outside the block. The walker is the only agent that touches that memory while it is busy, and it issues at most one read or one write per clock. Each header dword carries a 16-bit identifier, a 4-bit version and a 12-bit byte pointer to the next header, where zero marks the tail.

A search request takes an identifier and walks the chain from byte offset 0x100. The walk stops on the first header whose identifier matches or on the tail. Every result reports the matching position and the position visited just before it. A search that misses reports the tail as the predecessor.

An append request takes an identifier, a version, a byte offset and a size. It first checks that the region is legal. Unless the new entry goes at 0x100, it then walks with matching switched off to reach the tail. It rewrites the tail's pointer field to point at the new entry, and writes the new header as a fresh tail. Pointers that are out of range or misaligned, and chains that loop, end the operation with an error instead of hanging it.

Top module: `xcap_chain_walker`

## Requirements
- R1: A header dword is decoded as identifier in bits 15:0, version in bits 19:16 and next byte pointer in bits 31:20. Every header the block writes uses the same layout.
- R2: If the dword at byte 0x100 is all zeros, a search completes with res_found=0, res_pos=0, res_prev=0 and res_err=0 after exactly one memory read.
- R3: A search stops at the first header in chain order whose identifier equals the request. It returns res_found=1, res_pos set to that header's byte offset, and res_prev set to the offset visited before it (0 when the match is at 0x100).
- R4: A search that reaches a header with next pointer 0 without a match returns res_found=0, res_pos=0 and res_prev set to that tail's byte offset.
- R5: A next pointer that must be followed is checked first. If it is below 0x100, above 0xFF8 or not a multiple of 4, the operation ends with res_err=1, res_found=0, res_pos=0 and res_prev=0, and that pointer is never read.
- R6: After MAX_HOPS (default 1024) followed links, an operation that would follow one more ends with res_err=1. A self-loop therefore costs exactly MAX_HOPS+1 reads.
- R7: An append whose offset is not 0x100 walks the chain without matching to the tail. It rewrites the tail dword with bits 31:20 set to the new offset and bits 19:0 unchanged. It reports res_pos equal to the offset and res_prev equal to the tail offset.
- R8: Every successful append writes the dword at the new offset as next=0, the requested version and the requested identifier.
- R9: An append at offset 0x100 performs no read and exactly one write, and reports res_prev=0.
- R10: An append is legal only when the offset is at least 0x100 and a multiple of 4, the size is at least 8, and offset plus size is no more than 0x1000. An illegal append ends with res_err=1 and no memory access.
- R11: An append at an offset other than 0x100 on an empty list ends with res_err=1 and no write.
- R12: done is high for exactly one cycle per operation. Requests that arrive while busy is high are ignored. When both requests are raised in the same idle cycle, the search is taken and the append is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| find_req | input | 1 | Start a search (sampled while idle) |
| find_id | input | 16 | Identifier to search for |
| app_req | input | 1 | Start an append (sampled while idle) |
| app_id | input | 16 | Identifier of the new entry |
| app_ver | input | 4 | Version of the new entry |
| app_ofs | input | 12 | Byte offset of the new entry |
| app_size | input | 13 | Size in bytes of the new entry |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse; results valid |
| res_found | output | 1 | Search matched |
| res_err | output | 1 | Operation ended with an error |
| res_pos | output | 12 | Matched offset (search) or new offset (append) |
| res_prev | output | 12 | Predecessor or tail offset |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 10 | Dword address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the read is issued |

## Verification
On every cycle the assertions check the following. done never lasts two cycles. No access ever falls outside the legal header window. An error result always carries zeroed position fields, and a found result never points below 0x100. An illegal append completes at once with an error. The hop counter is never stepped past its limit. The bench scenarios cover what needs whole-chain knowledge: first-match order with duplicate identifiers, the predecessor and tail values, the exact bits kept by the tail rewrite, the read counts for an empty list and for a loop, and the requests that are dropped while busy.

// File: rtl/xcw_pkg.sv
package xcw_pkg;
  localparam int ID_W  = 16;
  localparam int VER_W = 4;
  localparam int PTR_W = 12;
  localparam int HDR_W = ID_W + VER_W + PTR_W;

  typedef struct packed {
    logic [PTR_W-1:0] nxt;
    logic [VER_W-1:0] ver;
    logic [ID_W-1:0]  id;
  } xcw_hdr_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_DEC, S_PATCH, S_HEAD, S_FIN
  } xcw_state_e;
endpackage

// File: rtl/xcw_hdr_decode.sv
module xcw_hdr_decode
  import xcw_pkg::*;
(
  input  xcw_hdr_t         hdr,
  input  logic [ID_W-1:0]  tgt,
  output logic             hit,
  output logic             is_zero,
  output logic [PTR_W-1:0] nxt
);
  always_comb begin
    hit     = (hdr.id == tgt);
    is_zero = (hdr == '0);
    nxt     = hdr.nxt;
  end
endmodule

// File: rtl/xcw_ptr_check.sv
module xcw_ptr_check
  import xcw_pkg::*;
#(
  parameter int BASE_PTR = 256
) (
  input  logic [PTR_W-1:0] ptr,
  output logic             ok
);
  localparam int SPACE = 1 << PTR_W;
  localparam logic [PTR_W-1:0] LO = PTR_W'(BASE_PTR);
  localparam logic [PTR_W-1:0] HI = PTR_W'(SPACE - 8);

  always_comb begin
    ok = (ptr >= LO) && (ptr <= HI) && (ptr[1:0] == 2'b00);
  end
endmodule

// File: rtl/xcw_append_check.sv
module xcw_append_check
  import xcw_pkg::*;
#(
  parameter int BASE_PTR      = 256,
  parameter int MIN_CAP_BYTES = 8
) (
  input  logic [PTR_W-1:0] ofs,
  input  logic [PTR_W:0]   size,
  output logic             legal,
  output logic             direct
);
  localparam int SPACE = 1 << PTR_W;
  localparam logic [PTR_W-1:0] LO     = PTR_W'(BASE_PTR);
  localparam logic [PTR_W:0]   MIN_SZ = (PTR_W+1)'(MIN_CAP_BYTES);
  localparam logic [PTR_W+1:0] TOP    = (PTR_W+2)'(SPACE);

  logic [PTR_W+1:0] span;

  always_comb begin
    span   = {2'b00, ofs} + {1'b0, size};
    legal  = (ofs >= LO) && (ofs[1:0] == 2'b00) && (size >= MIN_SZ) && (span <= TOP);
    direct = (ofs == LO);
  end
endmodule

// File: rtl/xcw_hop_guard.sv
module xcw_hop_guard #(
  parameter int MAX_HOPS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_HOPS + 1);
  localparam logic [CW-1:0] LIM = CW'(MAX_HOPS);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                        cnt_d = '0;
    else if (inc && (cnt_q != LIM)) cnt_d = cnt_q + 1'b1;
    at_limit = (cnt_q == LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6: the walker never asks for a hop once the budget is spent
  p_no_hop_past_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !at_limit);
endmodule

// File: rtl/xcap_chain_walker.sv
module xcap_chain_walker
  import xcw_pkg::*;
#(
  parameter int BASE_PTR      = 256,
  parameter int MAX_HOPS      = 1024,
  parameter int MIN_CAP_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              find_req,
  input  logic [ID_W-1:0]   find_id,
  input  logic              app_req,
  input  logic [ID_W-1:0]   app_id,
  input  logic [VER_W-1:0]  app_ver,
  input  logic [PTR_W-1:0]  app_ofs,
  input  logic [PTR_W:0]    app_size,
  output logic              busy,
  output logic              done,
  output logic              res_found,
  output logic              res_err,
  output logic [PTR_W-1:0]  res_pos,
  output logic [PTR_W-1:0]  res_prev,
  output logic              mem_en,
  output logic              mem_we,
  output logic [PTR_W-3:0]  mem_addr,
  output logic [HDR_W-1:0]  mem_wdata,
  input  logic [HDR_W-1:0]  mem_rdata
);
  localparam int AW    = PTR_W - 2;
  localparam int SPACE = 1 << PTR_W;
  localparam logic [PTR_W-1:0] BASE_V  = PTR_W'(BASE_PTR);
  localparam logic [AW-1:0]    ADDR_LO = AW'(BASE_PTR / 4);
  localparam logic [AW-1:0]    ADDR_HI = AW'((SPACE - 8) / 4);

  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_n_i <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_n_i <= rst_s1;
    end
  end

  xcw_state_e       state_q, state_d;
  logic [PTR_W-1:0] cur_q, cur_d, prv_q, prv_d;
  logic             app_q, app_d;
  logic             cap_ld, hdr_ld, res_ld, hop_clr, hop_inc;
  logic [ID_W-1:0]  tgt_q, nid_q;
  logic [VER_W-1:0] nver_q;
  logic [PTR_W-1:0] nofs_q;
  xcw_hdr_t         hdr_q;
  logic             found_d, err_d;
  logic [PTR_W-1:0] pos_d, prev_d;

  logic             dec_hit, dec_zero, nxt_ok, hop_lim, app_legal, app_direct;
  logic [PTR_W-1:0] dec_nxt;

  xcw_hdr_decode u_dec (
    .hdr(hdr_q), .tgt(tgt_q), .hit(dec_hit), .is_zero(dec_zero), .nxt(dec_nxt)
  );

  xcw_ptr_check #(.BASE_PTR(BASE_PTR)) u_ptr (
    .ptr(dec_nxt), .ok(nxt_ok)
  );

  xcw_append_check #(.BASE_PTR(BASE_PTR), .MIN_CAP_BYTES(MIN_CAP_BYTES)) u_app (
    .ofs(app_ofs), .size(app_size), .legal(app_legal), .direct(app_direct)
  );

  xcw_hop_guard #(.MAX_HOPS(MAX_HOPS)) u_hop (
    .clk(clk), .rst_n(rst_n_i), .clr(hop_clr), .inc(hop_inc), .at_limit(hop_lim)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    prv_d     = prv_q;
    app_d     = app_q;
    cap_ld    = 1'b0;
    hdr_ld    = 1'b0;
    hop_clr   = 1'b0;
    hop_inc   = 1'b0;
    res_ld    = 1'b0;
    found_d   = 1'b0;
    err_d     = 1'b0;
    pos_d     = '0;
    prev_d    = '0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;

    unique case (state_q)
      S_IDLE: begin
        if (find_req) begin
          cap_ld  = 1'b1;
          app_d   = 1'b0;
          cur_d   = BASE_V;
          prv_d   = '0;
          hop_clr = 1'b1;
          state_d = S_ISSUE;
        end else if (app_req) begin
          cap_ld  = 1'b1;
          app_d   = 1'b1;
          cur_d   = BASE_V;
          prv_d   = '0;
          hop_clr = 1'b1;
          if (!app_legal) begin
            res_ld  = 1'b1;
            err_d   = 1'b1;
            state_d = S_FIN;
          end else if (app_direct) begin
            state_d = S_HEAD;
          end else begin
            state_d = S_ISSUE;
          end
        end
      end

      S_ISSUE: begin
        mem_en   = 1'b1;
        mem_addr = cur_q[PTR_W-1:2];
        state_d  = S_WAIT;
      end

      S_WAIT: begin
        hdr_ld  = 1'b1;
        state_d = S_DEC;
      end

      S_DEC: begin
        if (dec_zero && (prv_q == '0)) begin
          res_ld  = 1'b1;
          err_d   = app_q;
          state_d = S_FIN;
        end else if (!app_q && dec_hit) begin
          res_ld  = 1'b1;
          found_d = 1'b1;
          pos_d   = cur_q;
          prev_d  = prv_q;
          state_d = S_FIN;
        end else if (dec_nxt == '0) begin
          if (app_q) begin
            state_d = S_PATCH;
          end else begin
            res_ld  = 1'b1;
            prev_d  = cur_q;
            state_d = S_FIN;
          end
        end else if (!nxt_ok || hop_lim) begin
          res_ld  = 1'b1;
          err_d   = 1'b1;
          state_d = S_FIN;
        end else begin
          prv_d   = cur_q;
          cur_d   = dec_nxt;
          hop_inc = 1'b1;
          state_d = S_ISSUE;
        end
      end

      S_PATCH: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_q[PTR_W-1:2];
        mem_wdata = {nofs_q, hdr_q.ver, hdr_q.id};
        prv_d     = cur_q;
        state_d   = S_HEAD;
      end

      S_HEAD: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = nofs_q[PTR_W-1:2];
        mem_wdata = {{PTR_W{1'b0}}, nver_q, nid_q};
        res_ld    = 1'b1;
        pos_d     = nofs_q;
        prev_d    = prv_q;
        state_d   = S_FIN;
      end

      S_FIN: state_d = S_IDLE;

      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      prv_q   <= '0;
      app_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      prv_q   <= prv_d;
      app_q   <= app_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      tgt_q  <= '0;
      nid_q  <= '0;
      nver_q <= '0;
      nofs_q <= '0;
    end else if (cap_ld) begin
      tgt_q  <= find_id;
      nid_q  <= app_id;
      nver_q <= app_ver;
      nofs_q <= app_ofs;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)    hdr_q <= '0;
    else if (hdr_ld) hdr_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      res_found <= 1'b0;
      res_err   <= 1'b0;
      res_pos   <= '0;
      res_prev  <= '0;
    end else if (res_ld) begin
      res_found <= found_d;
      res_err   <= err_d;
      res_pos   <= pos_d;
      res_prev  <= prev_d;
    end
  end

  always_comb begin
    busy = (state_q != S_IDLE);
    done = (state_q == S_FIN);
  end

  // R12: completion is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |=> !done);

  // R5: no access ever leaves the legal header window
  p_mem_window_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    mem_en |-> ((mem_addr >= ADDR_LO) && (mem_addr <= ADDR_HI)));

  // R5: an error result carries zeroed position fields
  p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (done && res_err) |-> (!res_found && (res_pos == '0) && (res_prev == '0)));

  // R3: a match always points inside the extended region
  p_found_pos_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (done && res_found) |-> ((res_pos >= BASE_V) && !res_err));

  // R10: an illegal append completes at once with an error
  p_illegal_quick_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    ((state_q == S_IDLE) && app_req && !find_req && !app_legal)
      |=> (done && res_err && !mem_en));
endmodule

// File: tb/xcap_chain_walker_test.sv
module xcap_chain_walker_test;
  localparam int MAXH = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        find_req, app_req;
  logic [15:0] find_id, app_id;
  logic [3:0]  app_ver;
  logic [11:0] app_ofs;
  logic [12:0] app_size;
  logic        busy, done, res_found, res_err;
  logic [11:0] res_pos, res_prev;
  logic        mem_en, mem_we;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] mem [1024];
  int nrd, nwr;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  xcap_chain_walker uut (
    .clk(clk), .rst_n(rst_n),
    .find_req(find_req), .find_id(find_id),
    .app_req(app_req), .app_id(app_id), .app_ver(app_ver),
    .app_ofs(app_ofs), .app_size(app_size),
    .busy(busy), .done(done), .res_found(res_found), .res_err(res_err),
    .res_pos(res_pos), .res_prev(res_prev),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        nwr <= nwr + 1;
      end else begin
        mem_rdata <= mem[mem_addr];
        nrd <= nrd + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (!done) begin
      @(negedge clk);
      t++;
      if (t > 4000) begin
        total++;
        bad++;
        $display("FAIL R12 watchdog: act=0 exp=1 (done never rose)");
        break;
      end
    end
  endtask

  task automatic op(input bit f, input bit a, input logic [15:0] fid, input logic [15:0] aid,
                    input logic [3:0] aver, input logic [11:0] aofs, input logic [12:0] asz,
                    input bit poke);
    @(negedge clk);
    nrd = 0; nwr = 0;
    find_req = f; find_id = fid;
    app_req = a; app_id = aid; app_ver = aver; app_ofs = aofs; app_size = asz;
    @(negedge clk);
    find_req = 1'b0; app_req = 1'b0;
    if (poke) begin
      app_req = 1'b1; app_ofs = 12'h100; app_size = 13'd8;
      @(negedge clk);
      app_req = 1'b0;
    end
    wait_done();
  endtask

  task automatic find(input logic [15:0] id);
    op(1'b1, 1'b0, id, 16'h0, 4'h0, 12'h0, 13'h0, 1'b0);
  endtask

  task automatic append(input logic [15:0] id, input logic [3:0] ver,
                        input logic [11:0] ofs, input logic [12:0] sz);
    op(1'b0, 1'b1, 16'h0, id, ver, ofs, sz, 1'b0);
  endtask

  task automatic check_res(input string tag, input bit ef, input bit ee,
                           input logic [11:0] ep, input logic [11:0] epv);
    chk({tag, " found"}, {31'h0, res_found}, {31'h0, ef});
    chk({tag, " err"},   {31'h0, res_err},   {31'h0, ee});
    chk({tag, " pos"},   {20'h0, res_pos},   {20'h0, ep});
    chk({tag, " prev"},  {20'h0, res_prev},  {20'h0, epv});
  endtask

  // reference walk over the bench memory, from the requirements
  task automatic ref_walk(input logic [15:0] id, input bit nomatch,
                          output bit f, output bit e, output logic [11:0] p, output logic [11:0] pv);
    logic [11:0] cur, nx;
    logic [31:0] h;
    int hops;
    f = 0; e = 0; p = 0; pv = 0; cur = 12'h100; hops = 0;
    if (mem[cur[11:2]] == 32'h0) begin
      e = nomatch;
      return;
    end
    forever begin
      h = mem[cur[11:2]];
      if (!nomatch && h[15:0] == id) begin f = 1; p = cur; return; end
      nx = h[31:20];
      if (nx == 12'h0) begin pv = cur; return; end
      if (nx < 12'h100 || nx > 12'hFF8 || nx[1:0] != 2'b00 || hops >= MAXH) begin
        e = 1; pv = 0; return;
      end
      pv = cur; cur = nx; hops++;
    end
  endtask

  logic [11:0] cpos [8];
  bit          used [48];

  task automatic build_chain(input int n);
    int s;
    clear_mem();
    for (int i = 0; i < 48; i++) used[i] = 0;
    used[0] = 1;
    cpos[0] = 12'h100;
    for (int k = 1; k < n; k++) begin
      do s = $urandom_range(1, 47); while (used[s]);
      used[s] = 1;
      cpos[k] = 12'(12'h100 + s * 12'h40);
    end
    for (int k = 0; k < n; k++) begin
      mem[cpos[k][11:2]] = {(k < n-1) ? cpos[k+1] : 12'h0,
                            4'($urandom_range(0, 15)), 16'($urandom_range(1, 5))};
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ef, ee;
    logic [11:0] ep, epv, tail;
    logic [31:0] old;
    logic [3:0] v;
    int n;
    int qid;

    void'($urandom(32'd2024));
    rst_n = 1'b0;
    find_req = 0; app_req = 0; find_id = 0; app_id = 0; app_ver = 0; app_ofs = 0; app_size = 0;
    nrd = 0; nwr = 0;
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("RST busy", {31'h0, busy}, 32'h0);
    chk("RST done", {31'h0, done}, 32'h0);
    chk("RST mem_en", {31'h0, mem_en}, 32'h0);
    chk("RST err", {31'h0, res_err}, 32'h0);

    // R2: empty list
    find(16'h5);
    check_res("R2", 0, 0, 12'h0, 12'h0);
    chk("R2 reads", nrd, 1);

    // R9 / R8 / R1: append at the base
    append(16'h0001, 4'h2, 12'h100, 13'd8);
    check_res("R9", 0, 0, 12'h100, 12'h0);
    chk("R9 reads", nrd, 0);
    chk("R9 writes", nwr, 1);
    chk("R8 R1 head word", mem[12'h100 >> 2], 32'h0002_0001);

    // R7: append behind the tail
    append(16'h0003, 4'h1, 12'h180, 13'd32);
    check_res("R7", 0, 0, 12'h180, 12'h100);
    chk("R7 R1 tail patched", mem[12'h100 >> 2], 32'h1802_0001);
    chk("R8 new header", mem[12'h180 >> 2], 32'h0001_0003);

    // R3 / R4
    find(16'h3);
    check_res("R3 second", 1, 0, 12'h180, 12'h100);
    find(16'h1);
    check_res("R3 head", 1, 0, 12'h100, 12'h0);
    find(16'h9);
    check_res("R4 miss", 0, 0, 12'h0, 12'h180);

    // R10: illegal appends touch nothing
    append(16'h7, 4'h0, 12'h0F0, 13'd8);
    check_res("R10 low", 0, 1, 12'h0, 12'h0);
    chk("R10 low accesses", nrd + nwr, 0);
    append(16'h7, 4'h0, 12'h200, 13'd4);
    check_res("R10 size", 0, 1, 12'h0, 12'h0);
    chk("R10 size accesses", nrd + nwr, 0);
    append(16'h7, 4'h0, 12'hFFC, 13'd8);
    check_res("R10 overflow", 0, 1, 12'h0, 12'h0);
    chk("R10 overflow accesses", nrd + nwr, 0);
    append(16'h7, 4'h0, 12'h182, 13'd8);
    check_res("R10 align", 0, 1, 12'h0, 12'h0);
    chk("R10 align accesses", nrd + nwr, 0);
    append(16'h00AB, 4'h5, 12'hFF8, 13'd8);
    check_res("R10 edge legal", 0, 0, 12'hFF8, 12'h180);
    chk("R7 edge patch", mem[12'h180 >> 2], 32'hFF81_0003);
    chk("R8 edge header", mem[12'hFF8 >> 2], 32'h0005_00AB);
    find(16'hAB);
    check_res("R3 last slot", 1, 0, 12'hFF8, 12'h180);

    // R11: append on an empty list
    clear_mem();
    append(16'h7, 4'h0, 12'h200, 13'd8);
    check_res("R11", 0, 1, 12'h0, 12'h0);
    chk("R11 writes", nwr, 0);

    // R5: bad pointers stop the walk before reading them
    mem[12'h100 >> 2] = {12'h0C0, 4'h0, 16'h2};
    find(16'h7);
    check_res("R5 low", 0, 1, 12'h0, 12'h0);
    chk("R5 low reads", nrd, 1);
    mem[12'h100 >> 2] = {12'h102, 4'h0, 16'h2};
    find(16'h7);
    check_res("R5 align", 0, 1, 12'h0, 12'h0);
    chk("R5 align reads", nrd, 1);
    mem[12'h100 >> 2] = {12'hFFC, 4'h0, 16'h2};
    find(16'h7);
    check_res("R5 high", 0, 1, 12'h0, 12'h0);
    chk("R5 high reads", nrd, 1);

    // R6: self-loop
    mem[12'h100 >> 2] = {12'h100, 4'h0, 16'h5};
    find(16'h7);
    check_res("R6 loop", 0, 1, 12'h0, 12'h0);
    chk("R6 loop reads", nrd, MAXH + 1);
    find(16'h5);
    check_res("R6 match before loop", 1, 0, 12'h100, 12'h0);

    // R12: busy ignores requests, search wins a tie, done is one cycle
    clear_mem();
    mem[12'h100 >> 2] = {12'h140, 4'h0, 16'h1};
    mem[12'h140 >> 2] = {12'h000, 4'h0, 16'h2};
    op(1'b1, 1'b0, 16'h2, 16'h0, 4'h0, 12'h0, 13'h0, 1'b1);
    check_res("R12 busy", 1, 0, 12'h140, 12'h100);
    chk("R12 busy writes", nwr, 0);
    @(negedge clk);
    chk("R12 done pulse", {31'h0, done}, 32'h0);
    op(1'b1, 1'b1, 16'h2, 16'h9, 4'h3, 12'h100, 13'd8, 1'b0);
    check_res("R12 tie", 1, 0, 12'h140, 12'h100);
    chk("R12 tie writes", nwr, 0);
    chk("R12 head intact", mem[12'h100 >> 2], 32'h1400_0001);

    // random chains
    for (int it = 0; it < 20; it++) begin
      n = $urandom_range(1, 8);
      build_chain(n);
      for (int q = 0; q < 3; q++) begin
        qid = $urandom_range(1, 6);
        ref_walk(16'(qid), 0, ef, ee, ep, epv);
        find(16'(qid));
        check_res(ef ? "R3 rand" : "R4 rand", ef, ee, ep, epv);
      end
      ref_walk(16'h0, 1, ef, ee, ep, tail);
      old = mem[tail[11:2]];
      v = 4'($urandom_range(0, 15));
      append(16'h007A, v, 12'hF00, 13'd16);
      check_res("R7 rand", 0, 0, 12'hF00, tail);
      chk("R7 rand tail", mem[tail[11:2]], {12'hF00, old[19:0]});
      chk("R8 rand header", mem[12'hF00 >> 2], {12'h0, v, 16'h007A});
      chk("R7 rand writes", nwr, 2);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule